// File: doc/BRIEF.md
# HDLC Receive Frame Length Counter

This block sits beside the receive side of a transparent-mode HDLC channel. It counts every byte that the receiver writes into its FIFO. When the frame ends it captures the total length and an overflow flag into two read-only byte registers, and raises a one-cycle end-of-message interrupt. The host then reads the two registers and drains the last partial FIFO block. The block tells it how large that block is: the length reduced modulo the FIFO threshold, or the full threshold when nothing remains.

The captured result stays frozen until the host issues the receive-acknowledge command. A frame that ends while the previous result is still unacknowledged is parked in a one-deep holding slot. It is published, with its own interrupt, at the acknowledge. The running counter saturates at 4096 so that a very long message never wraps into a short, plausible length.

Top module: `hdlc_rx_length_unit`

## Requirements
- R1: After reset, reads of the low register (address 2Bh) and the high register (address 2Ch) return 00h, `eom_irq` is 0 and `avail_cnt` is 0.
- R2: A frame of N bytes (1 to 4096) is reported as N. The low register holds bits 7..0 of N and the high register bits 4..0 hold bits 12..8 of N. `eom_irq` is high for exactly the one cycle after the clock edge that takes the frame end, provided no earlier result is still unacknowledged.
- R3: A frame of 4097 bytes or more sets bit 7 of the high register. The reported length saturates at 4096 and never wraps, even past 8192 bytes.
- R4: Once published, the length and the overflow bit stay unchanged until acknowledge, while bytes of following frames arrive.
- R5: `ack_cmd` clears the overflow bit and drops `avail_cnt` to 0. The length bits keep their value.
- R6: A frame that ends while a result is unacknowledged raises no interrupt. It is published, with `eom_irq`, at the edge that takes the acknowledge. A later frame ending before that acknowledge replaces the parked one.
- R7: While a result is published, `avail_cnt` equals length mod T, or T when that remainder is 0. T = 8 << `thr_sel` (codes 0..3 give 8, 16, 32, 64), and `thr_sel` acts at once.
- R8: `frame_end` with no byte received since the previous frame end is ignored: no interrupt and no register change.
- R9: `rd_data` is registered. It shows the addressed register in the cycle after `rd_en`, and 00h for any other address or when `rd_en` is low. Bits 6..5 of the high register read 0.
- R10: A byte strobed in the same cycle as `frame_end` belongs to the frame that ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_vld | input | 1 | One received byte written to the FIFO |
| frame_end | input | 1 | End of the current frame |
| ack_cmd | input | 1 | Host receive-acknowledge command |
| thr_sel | input | 2 | FIFO threshold code, T = 8 << thr_sel |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Registered read data |
| eom_irq | output | 1 | End-of-message interrupt pulse |
| avail_cnt | output | 7 | Bytes left in the FIFO for the final read |

## Verification
The hardest states to reach are saturation and the parked second result. Saturation needs thousands of consecutive byte strobes, so the bench sends whole frames of 4095, 4096, 4097 and 8193 bytes. The 8193-byte frame is the one that would wrap a 13-bit counter back to 1. To park a result, the bench leaves one frame unacknowledged and then delivers two more: the first arrives split around a register read, and the second replaces it. The acknowledge must then publish only the newest frame. A sweep over every length from 1 to 140, with gaps and separate end strobes mixed in, checks the registers and the final-block size under all four threshold codes.

// File: rtl/hrl_pkg.sv
// Shared widths and the frame result record for the receive length counter.
// Assumes a 13-bit length field with a maximum legal length of 4096 bytes.
package hrl_pkg;
    localparam int LEN_W = 13;
    localparam logic [LEN_W-1:0] LEN_MAX = 13'd4096;

    typedef struct packed {
        logic             ovf;
        logic [LEN_W-1:0] len;
    } frame_res_t;
endpackage

// File: rtl/hrl_byte_counter.sv
// Running byte counter for the frame in progress.
// Restarts at 1 on the first byte after a frame end and saturates at LEN_MAX,
// setting the overflow flag on any further byte. It offers the counter's next
// value so a byte arriving together with frame_end is included.
module hrl_byte_counter
    import hrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_vld,
    input  logic       frame_end,
    output frame_res_t nxt,
    output logic       fe_evt
);
    logic [LEN_W-1:0] cnt_q;
    logic             ovf_q;
    logic             in_frame_q;

    // Next count: restart, saturate or increment.
    always_comb begin
        nxt.len = cnt_q;
        nxt.ovf = ovf_q;
        if (byte_vld) begin
            if (!in_frame_q) begin
                nxt.len = LEN_W'(1);
                nxt.ovf = 1'b0;
            end else if (cnt_q == LEN_MAX) begin
                nxt.ovf = 1'b1;
            end else begin
                nxt.len = cnt_q + 1'b1;
            end
        end
    end

    // A frame end counts only if at least one byte belongs to the frame.
    always_comb fe_evt = frame_end && (in_frame_q || byte_vld);

    // Counter state and frame-open flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            ovf_q      <= 1'b0;
            in_frame_q <= 1'b0;
        end else begin
            cnt_q <= nxt.len;
            ovf_q <= nxt.ovf;
            if (frame_end)     in_frame_q <= 1'b0;
            else if (byte_vld) in_frame_q <= 1'b1;
        end
    end

    // R3: a byte at the limit keeps the count and flags overflow.
    p_saturate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && in_frame_q && cnt_q == LEN_MAX) |=> (cnt_q == LEN_MAX && ovf_q));

    // R2: the first byte of a frame restarts the count at one.
    p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !in_frame_q) |=> (cnt_q == LEN_W'(1) && !ovf_q));
endmodule

// File: rtl/hrl_result_hold.sv
// Published frame result plus a one-deep parking slot.
// Assumes fe_evt and nxt come from the byte counter in the same cycle. A result
// is published when none is held or when an acknowledge frees the register.
module hrl_result_hold
    import hrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  frame_res_t nxt,
    input  logic       fe_evt,
    input  logic       ack_cmd,
    output frame_res_t res,
    output logic       res_vld,
    output logic       eom_irq
);
    frame_res_t res_q, pend_q;
    logic       res_vld_q, pend_vld_q, irq_q;
    logic       free_now;

    // The published register may be rewritten this cycle.
    always_comb free_now = !res_vld_q || ack_cmd;

    // Publish, park, promote and acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q      <= '0;
            pend_q     <= '0;
            res_vld_q  <= 1'b0;
            pend_vld_q <= 1'b0;
            irq_q      <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (ack_cmd) begin
                res_q.ovf <= 1'b0;
                res_vld_q <= 1'b0;
            end
            if (free_now) begin
                if (pend_vld_q) begin
                    res_q      <= pend_q;
                    res_vld_q  <= 1'b1;
                    irq_q      <= 1'b1;
                    pend_vld_q <= fe_evt;
                    if (fe_evt) pend_q <= nxt;
                end else if (fe_evt) begin
                    res_q     <= nxt;
                    res_vld_q <= 1'b1;
                    irq_q     <= 1'b1;
                end
            end else if (fe_evt) begin
                pend_q     <= nxt;
                pend_vld_q <= 1'b1;
            end
        end
    end

    assign res     = res_q;
    assign res_vld = res_vld_q;
    assign eom_irq = irq_q;

    // R4: a held result does not move without an acknowledge.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld_q && !ack_cmd) |=> ($stable(res_q.len) && $stable(res_q.ovf)));

    // R5: an acknowledge with nothing to publish clears overflow and validity.
    p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_cmd && !pend_vld_q && !fe_evt) |=> (!res_q.ovf && !res_vld_q));

    // R6: a result is parked only behind a held result.
    p_park_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pend_vld_q |-> res_vld_q);

    // R2: the interrupt marks a freshly published result.
    p_irq_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> res_vld_q);
endmodule

// File: rtl/hrl_avail_calc.sv
// Final FIFO block size: length modulo a power-of-two threshold, or the full
// threshold when the remainder is zero. One candidate is built per threshold
// code and thr_sel picks among them. The output is zero while nothing is held.
module hrl_avail_calc
    import hrl_pkg::*;
#(
    parameter int THR_BASE_LOG = 3,
    parameter int THR_SEL_W    = 2,
    parameter int AVAIL_W      = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  frame_res_t           res,
    input  logic                 res_vld,
    input  logic [THR_SEL_W-1:0] thr_sel,
    output logic [AVAIL_W-1:0]   avail
);
    localparam int NUM_THR = 1 << THR_SEL_W;

    logic [AVAIL_W-1:0] cand [NUM_THR];

    // One masked remainder per threshold.
    for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
        localparam int RW  = THR_BASE_LOG + g;
        localparam int THR = 1 << RW;
        logic [RW-1:0] rem;
        assign rem     = res.len[RW-1:0];
        assign cand[g] = (rem == '0) ? AVAIL_W'(THR) : AVAIL_W'(rem);
    end

    // Pick the active threshold's candidate.
    always_comb avail = res_vld ? cand[thr_sel] : '0;

    // R7: a published result always leaves between 1 and T bytes.
    p_avail_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> (avail != '0 && 32'(avail) <= (32'd1 << (THR_BASE_LOG + 32'(thr_sel)))));
endmodule

// File: rtl/hrl_reg_read.sv
// Registered read port for the low and high length registers.
// High register layout: bit 7 overflow, the upper length bits at the bottom and
// zeros between them. Unmapped addresses and idle cycles return zero.
module hrl_reg_read
    import hrl_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] LO_ADDR = 8'h2B,
    parameter logic [ADDR_W-1:0] HI_ADDR = 8'h2C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  frame_res_t        res,
    output logic [7:0]        rd_data
);
    localparam int HI_BITS = LEN_W - 8;
    localparam int PAD_W   = 7 - HI_BITS;

    logic [7:0] hi_byte;

    // Assemble the high register image.
    always_comb hi_byte = {res.ovf, {PAD_W{1'b0}}, res.len[LEN_W-1:8]};

    // Decode and register the read data.
    always_ff @(posedge clk) begin
        if (!rst_n)                           rd_data <= '0;
        else if (rd_en && rd_addr == LO_ADDR) rd_data <= res.len[7:0];
        else if (rd_en && rd_addr == HI_ADDR) rd_data <= hi_byte;
        else                                  rd_data <= '0;
    end

    // R9: an idle cycle yields zero read data.
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rd_data == 8'h00));
endmodule

// File: rtl/hdlc_rx_length_unit.sv
// Top of the transparent-mode receive length counter.
// Connects the byte counter, the result holder, the final block calculator
// and the register read port. Assumes byte_vld pulses once per stored byte.
module hdlc_rx_length_unit
    import hrl_pkg::*;
#(
    parameter int                THR_BASE_LOG = 3,
    parameter int                THR_SEL_W    = 2,
    parameter int                ADDR_W       = 8,
    parameter logic [ADDR_W-1:0] LO_ADDR      = 8'h2B,
    parameter logic [ADDR_W-1:0] HI_ADDR      = 8'h2C,
    localparam int               AVAIL_W      = THR_BASE_LOG + (1 << THR_SEL_W)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 byte_vld,
    input  logic                 frame_end,
    input  logic                 ack_cmd,
    input  logic [THR_SEL_W-1:0] thr_sel,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [7:0]           rd_data,
    output logic                 eom_irq,
    output logic [AVAIL_W-1:0]   avail_cnt
);
    frame_res_t nxt, res;
    logic       fe_evt, res_vld;

    hrl_byte_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .frame_end(frame_end),
        .nxt(nxt), .fe_evt(fe_evt)
    );

    hrl_result_hold u_hold (
        .clk(clk), .rst_n(rst_n), .nxt(nxt), .fe_evt(fe_evt), .ack_cmd(ack_cmd),
        .res(res), .res_vld(res_vld), .eom_irq(eom_irq)
    );

    hrl_avail_calc #(
        .THR_BASE_LOG(THR_BASE_LOG), .THR_SEL_W(THR_SEL_W), .AVAIL_W(AVAIL_W)
    ) u_avail (
        .clk(clk), .rst_n(rst_n), .res(res), .res_vld(res_vld),
        .thr_sel(thr_sel), .avail(avail_cnt)
    );

    hrl_reg_read #(
        .ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .res(res), .rd_data(rd_data)
    );
endmodule

// File: tb/hdlc_rx_length_unit_tb.sv
module hdlc_rx_length_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_vld = 1'b0, frame_end = 1'b0, ack_cmd = 1'b0, rd_en = 1'b0;
    logic [1:0] thr_sel = 2'd0;
    logic [7:0] rd_addr = 8'h00;
    logic [7:0] rd_data;
    logic       eom_irq;
    logic [6:0] avail_cnt;

    int n_cmp = 0, n_bad = 0, cyc = 0;

    always #10 clk = ~clk;

    hdlc_rx_length_unit u_dut (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .frame_end(frame_end),
        .ack_cmd(ack_cmd), .thr_sel(thr_sel), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .eom_irq(eom_irq), .avail_cnt(avail_cnt)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output int d);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0; rd_addr = 8'h00;
        d = int'(rd_data);
    endtask

    task automatic ack();
        ack_cmd = 1'b1;
        @(negedge clk);
        ack_cmd = 1'b0;
    endtask

    // Drive n bytes; frame_end rides on the last byte unless sep is set.
    task automatic send(input int n, input bit gap, input bit sep, input bit close);
        for (int i = 0; i < n; i++) begin
            byte_vld  = 1'b1;
            frame_end = close && !sep && (i == n - 1);
            @(negedge clk);
            byte_vld = 1'b0; frame_end = 1'b0;
            if (gap && i < n - 1) @(negedge clk);
        end
        if (close && sep) begin
            frame_end = 1'b1;
            @(negedge clk);
            frame_end = 1'b0;
        end
    endtask

    function automatic int exp_lo(input int n);
        return (n > 4096 ? 4096 : n) & 255;
    endfunction
    function automatic int exp_hi(input int n);
        return (n > 4096 ? 128 : 0) | (((n > 4096 ? 4096 : n) >> 8) & 31);
    endfunction
    function automatic int exp_av(input int n, input int s);
        int t = 8 << s;
        int l = n > 4096 ? 4096 : n;
        return (l % t == 0) ? t : l % t;
    endfunction

    // Full check of a just-ended frame, then acknowledge.
    task automatic check_frame(input int n);
        int d;
        chk("R2 irq", int'(eom_irq), 1);
        rd(8'h2B, d); chk(n > 4096 ? "R3 low" : "R2 low", d, exp_lo(n));
        chk("R2 irq pulse", int'(eom_irq), 0);
        rd(8'h2C, d); chk(n > 4096 ? "R3 high" : "R2 high", d, exp_hi(n));
        for (int s = 0; s < 4; s++) begin
            thr_sel = 2'(s); #1;
            chk("R7 avail", int'(avail_cnt), exp_av(n, s));
        end
        ack();
        chk("R5 avail cleared", int'(avail_cnt), 0);
        rd(8'h2C, d); chk("R5 ovf cleared", d, exp_hi(n) & 31);
        rd(8'h2B, d); chk("R5 low kept", d, exp_lo(n));
    endtask

    initial begin
        int d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq", int'(eom_irq), 0);
        chk("R1 avail", int'(avail_cnt), 0);
        rd(8'h2B, d); chk("R1 low", d, 0);
        rd(8'h2C, d); chk("R1 high", d, 0);

        // R2 R7 R10 sweep: gaps on some, separate end strobe on others
        for (int n = 1; n <= 140; n++) begin
            send(n, (n % 3) == 0, (n % 2) == 0, 1'b1);
            check_frame(n);
        end

        // R3 saturation and boundaries
        send(4095, 1'b0, 1'b0, 1'b1); check_frame(4095);
        send(4096, 1'b0, 1'b1, 1'b1); check_frame(4096);
        send(4097, 1'b0, 1'b0, 1'b1); check_frame(4097);
        send(8193, 1'b0, 1'b0, 1'b1); check_frame(8193);

        // R4 R6 parking and replacement
        send(10, 1'b0, 1'b0, 1'b1);
        chk("R2 irq A", int'(eom_irq), 1);
        send(7, 1'b0, 1'b0, 1'b0);
        rd(8'h2B, d); chk("R4 low held mid frame", d, 10);
        send(13, 1'b1, 1'b0, 1'b1);
        chk("R6 no irq while held", int'(eom_irq), 0);
        rd(8'h2B, d); chk("R4 low held", d, 10);
        // R9 unmapped address reads zero
        rd(8'h2A, d); chk("R9 unmapped", d, 0);
        send(30, 1'b0, 1'b0, 1'b1);
        chk("R6 no irq while held", int'(eom_irq), 0);
        thr_sel = 2'd1; #1;
        chk("R7 avail of held", int'(avail_cnt), 10);
        ack();
        chk("R6 irq at ack", int'(eom_irq), 1);
        rd(8'h2B, d); chk("R6 newest parked", d, 30);
        thr_sel = 2'd2; #1;
        chk("R7 avail T=32", int'(avail_cnt), 30);
        ack();
        chk("R6 nothing left", int'(eom_irq), 0);

        // R8 empty frame end ignored
        frame_end = 1'b1; @(negedge clk); frame_end = 1'b0;
        chk("R8 no irq", int'(eom_irq), 0);
        chk("R8 avail", int'(avail_cnt), 0);
        rd(8'h2B, d); chk("R8 low unchanged", d, 30);
        // R9 idle read data
        @(negedge clk);
        chk("R9 idle zero", int'(rd_data), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule